// File: doc/BRIEF.md
# Register command sequence validator

This block guards the entry of a register-programming command buffer. Each request names an operation kind with its parameters: target block mask, register offset, payload length in bytes and wrap size. The block decides in one cycle whether the operation may be appended. It answers one cycle later with an accept flag and an error code. On acceptance it advances its own buffer fill index and updates two small masks. The first mask says which operation classes may come next. The second records which classes have been completed since the buffer was last emptied.

The ordering rules form a small protocol. A block-select must open every run of writes. A lookup-table block write leaves only further writes legal. A kickoff request is only granted when the buffer holds at least one block-select and one register write. The caller supplies the buffer capacity in bytes. Every accepted operation costs an 8-byte header plus its payload. The command words themselves are produced elsewhere.

Top module: `rcs_validator`

## Requirements
- R1: After reset, or in the cycle after `buf_clear` is high, `fill_index` is 0, `done_mask` is 2'b00 and `next_ok` is 2'b01. In both masks bit 0 stands for block-select and bit 1 for register write.
- R2: A register write (kinds 1 single, 2 incrementing, 3 indexed, 4 lookup-table) is rejected with error 2 (order) while `next_ok` bit 1 is clear, for example before any block-select has been accepted.
- R3: After an accepted block-select (kind 0), `next_ok` becomes 2'b10. After an accepted single, incrementing or indexed write it becomes 2'b11. After an accepted lookup-table write it becomes 2'b10. A block-select seen while `next_ok` bit 0 is clear is rejected with error 2.
- R4: A block-select is rejected with error 4 when its mask is zero. It is rejected with error 5 when the mask sets bits in both the video group (bits 3:0) and the post-processing group (bits 7:4).
- R5: A write is rejected with error 7 when its offset exceeds the offset limit (default 0xFFFFF) or is not a multiple of 4.
- R6: A write is rejected with error 6 when its length is not a multiple of 4 bytes or exceeds the dword limit (default 16383 dwords).
- R7: A lookup-table write is rejected with error 8 unless its wrap size lies in 2..15. Other operation kinds ignore the wrap size.
- R8: A block-select or write is rejected with error 3 when capacity minus fill index is less than 8 plus the payload length. An exact fit is accepted.
- R9: An accepted block-select advances `fill_index` by 8 and sets `done_mask` bit 0. An accepted write advances it by 8 plus the length and sets `done_mask` bit 1.
- R10: A rejected operation leaves `fill_index`, `next_ok` and `done_mask` unchanged.
- R11: A kickoff (kind 5) is accepted only when `done_mask` is 2'b11 and `fill_index` is non-zero; otherwise it is rejected with error 9. A kickoff never changes the state.
- R12: Kinds 6 and 7 are rejected with error 1. An accepted operation reports error 0.
- R13: When several checks fail, the reported error follows this priority: kind, then order, then space. After space, a block-select reports empty before mixed. A write reports length, then offset, then wrap.
- R14: When `buf_clear` and `op_valid` are high in the same cycle, the clear wins. No response is produced (`resp_valid` stays low) and the state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_clear | input | 1 | Empty the buffer and restart the protocol |
| op_valid | input | 1 | A request is presented this cycle |
| op_kind | input | 3 | Operation kind, 0..5 defined |
| blk_mask | input | GRP_A_W+GRP_B_W (8) | Target block mask for block-select |
| wr_offset | input | 32 | Register offset in bytes for writes |
| data_len | input | 32 | Payload length in bytes |
| wrap_size | input | WRAP_W (5) | Wrap size for lookup-table writes |
| buf_cap | input | IDX_W (16) | Buffer capacity in bytes |
| resp_valid | output | 1 | Response for the request of the previous cycle |
| resp_ok | output | 1 | Request accepted |
| resp_err | output | 4 | Error code, 0 when accepted |
| fill_index | output | IDX_W (16) | Bytes used in the buffer |
| next_ok | output | 2 | Legal next classes: bit 0 select, bit 1 write |
| done_mask | output | 2 | Completed classes: bit 0 select, bit 1 write |

## Verification
The bench builds the block with a 10-bit index and a dword limit of 15. The default limit of 16383 dwords cannot be reached: a payload that large would trip the space check first. With a limit of 15, the length error and its priority against the space error can both be exercised with a buffer of a few hundred bytes. This setting allows an exhaustive sweep of all 256 block masks and of every length from 0 to 70 bytes. It also allows a sweep of every wrap value from 0 to 31, alongside directed ordering, exact-fit and priority sequences. Every outcome is compared with a model in the bench that tracks the index and both masks.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  localparam int NEED_W  = 34;
  localparam int HDR_B   = 8;

  localparam logic [2:0] K_SELECT = 3'd0;
  localparam logic [2:0] K_WR_ONE = 3'd1;
  localparam logic [2:0] K_WR_INC = 3'd2;
  localparam logic [2:0] K_WR_IDX = 3'd3;
  localparam logic [2:0] K_WR_LUT = 3'd4;
  localparam logic [2:0] K_KICK   = 3'd5;

  localparam logic [1:0] CL_SEL = 2'b01;
  localparam logic [1:0] CL_WR  = 2'b10;

  typedef enum logic [3:0] {
    E_NONE   = 4'd0,
    E_KIND   = 4'd1,
    E_ORDER  = 4'd2,
    E_SPACE  = 4'd3,
    E_EMPTY  = 4'd4,
    E_MIX    = 4'd5,
    E_LENGTH = 4'd6,
    E_OFFSET = 4'd7,
    E_WRAP   = 4'd8,
    E_KICK   = 4'd9
  } rcs_err_e;

  function automatic logic kind_is_write(logic [2:0] k);
    return (k >= K_WR_ONE) && (k <= K_WR_LUT);
  endfunction

  function automatic logic kind_known(logic [2:0] k);
    return k <= K_KICK;
  endfunction

  // bytes an operation occupies in the buffer
  function automatic logic [NEED_W-1:0] need_bytes(logic [2:0] k, logic [31:0] len);
    logic [NEED_W-1:0] r;
    if (k == K_SELECT)        r = NEED_W'(HDR_B);
    else if (kind_is_write(k)) r = NEED_W'(HDR_B) + NEED_W'(len);
    else                      r = '0;
    return r;
  endfunction

endpackage

// File: rtl/rcs_sel_check.sv
module rcs_sel_check #(
  parameter int GRP_A_W = 4,
  parameter int GRP_B_W = 4,
  localparam int MASK_W = GRP_A_W + GRP_B_W
) (
  input  logic [MASK_W-1:0] mask,
  output logic              mask_empty,
  output logic              mask_mixed
);
  logic [GRP_A_W-1:0] grp_a;
  logic [GRP_B_W-1:0] grp_b;

  assign grp_a      = mask[GRP_A_W-1:0];
  assign grp_b      = mask[MASK_W-1:GRP_A_W];
  assign mask_empty = (mask == '0);
  assign mask_mixed = (|grp_a) && (|grp_b);
endmodule

// File: rtl/rcs_wr_check.sv
module rcs_wr_check #(
  parameter int unsigned OFF_MAX    = 32'hFFFFF,
  parameter int unsigned LEN_DW_MAX = 16383,
  parameter int unsigned WRAP_MIN   = 2,
  parameter int unsigned WRAP_MAX   = 15,
  parameter int          WRAP_W     = 5
) (
  input  logic [31:0]       offset,
  input  logic [31:0]       len,
  input  logic [WRAP_W-1:0] wrap,
  output logic              len_bad,
  output logic              off_bad,
  output logic              wrap_bad
);
  logic [29:0] len_dw;

  assign len_dw   = len[31:2];
  assign len_bad  = (len[1:0] != 2'b00) || (len_dw > 30'(LEN_DW_MAX));
  assign off_bad  = (offset[1:0] != 2'b00) || (offset > 32'(OFF_MAX));
  assign wrap_bad = (wrap < WRAP_W'(WRAP_MIN)) || (wrap > WRAP_W'(WRAP_MAX));
endmodule

// File: rtl/rcs_space_check.sv
module rcs_space_check
  import rcs_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic [IDX_W-1:0]  index,
  input  logic [IDX_W-1:0]  cap,
  input  logic [NEED_W-1:0] need,
  output logic              short_space
);
  logic [IDX_W-1:0] remain;

  assign remain      = (cap >= index) ? (cap - index) : '0;
  assign short_space = (NEED_W'(remain) < need);
endmodule

// File: rtl/rcs_track.sv
module rcs_track
  import rcs_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              commit,
  input  logic [2:0]        kind,
  input  logic [NEED_W-1:0] need,
  output logic [IDX_W-1:0]  index,
  output logic [1:0]        next_ok,
  output logic [1:0]        done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index   <= '0;
      next_ok <= CL_SEL;
      done    <= '0;
    end else if (clear) begin
      index   <= '0;
      next_ok <= CL_SEL;
      done    <= '0;
    end else if (commit) begin
      case (kind)
        K_SELECT: begin
          index   <= index + need[IDX_W-1:0];
          next_ok <= CL_WR;
          done    <= done | CL_SEL;
        end
        K_WR_ONE, K_WR_INC, K_WR_IDX: begin
          index   <= index + need[IDX_W-1:0];
          next_ok <= CL_WR | CL_SEL;
          done    <= done | CL_WR;
        end
        K_WR_LUT: begin
          index   <= index + need[IDX_W-1:0];
          next_ok <= CL_WR;
          done    <= done | CL_WR;
        end
        default: ;
      endcase
    end
  end

  a_r1_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (index == '0) && (done == 2'b00) && (next_ok == CL_SEL));

  a_r9_index_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !clear && kind != K_KICK) |=> (index > $past(index)));
endmodule

// File: rtl/rcs_validator.sv
module rcs_validator
  import rcs_pkg::*;
#(
  parameter int          IDX_W      = 16,
  parameter int          GRP_A_W    = 4,
  parameter int          GRP_B_W    = 4,
  parameter int unsigned OFF_MAX    = 32'hFFFFF,
  parameter int unsigned LEN_DW_MAX = 16383,
  parameter int unsigned WRAP_MIN   = 2,
  parameter int unsigned WRAP_MAX   = 15,
  parameter int          WRAP_W     = 5,
  localparam int         MASK_W     = GRP_A_W + GRP_B_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_clear,
  input  logic              op_valid,
  input  logic [2:0]        op_kind,
  input  logic [MASK_W-1:0] blk_mask,
  input  logic [31:0]       wr_offset,
  input  logic [31:0]       data_len,
  input  logic [WRAP_W-1:0] wrap_size,
  input  logic [IDX_W-1:0]  buf_cap,
  output logic              resp_valid,
  output logic              resp_ok,
  output logic [3:0]        resp_err,
  output logic [IDX_W-1:0]  fill_index,
  output logic [1:0]        next_ok,
  output logic [1:0]        done_mask
);
  // named internal events
  logic              is_sel, is_wr, is_lut, is_kick, known;
  logic              mask_empty, mask_mixed;
  logic              len_bad, off_bad, wrap_bad;
  logic              short_space;
  logic [NEED_W-1:0] need;
  rcs_err_e          verdict;
  logic              op_fire, accept, commit;

  assign known   = kind_known(op_kind);
  assign is_sel  = (op_kind == K_SELECT);
  assign is_wr   = kind_is_write(op_kind);
  assign is_lut  = (op_kind == K_WR_LUT);
  assign is_kick = (op_kind == K_KICK);
  assign need    = need_bytes(op_kind, data_len);

  rcs_sel_check #(.GRP_A_W(GRP_A_W), .GRP_B_W(GRP_B_W)) u_sel (
    .mask(blk_mask), .mask_empty(mask_empty), .mask_mixed(mask_mixed));

  rcs_wr_check #(.OFF_MAX(OFF_MAX), .LEN_DW_MAX(LEN_DW_MAX),
                 .WRAP_MIN(WRAP_MIN), .WRAP_MAX(WRAP_MAX), .WRAP_W(WRAP_W)) u_wr (
    .offset(wr_offset), .len(data_len), .wrap(wrap_size),
    .len_bad(len_bad), .off_bad(off_bad), .wrap_bad(wrap_bad));

  rcs_space_check #(.IDX_W(IDX_W)) u_space (
    .index(fill_index), .cap(buf_cap), .need(need), .short_space(short_space));

  // priority: kind > order > space > per-kind parameter checks
  always_comb begin
    verdict = E_NONE;
    if (!known)                           verdict = E_KIND;
    else if (is_kick)                     verdict = ((done_mask != 2'b11) || (fill_index == '0)) ? E_KICK : E_NONE;
    else if (is_sel && !next_ok[0])       verdict = E_ORDER;
    else if (is_wr && !next_ok[1])        verdict = E_ORDER;
    else if (short_space)                 verdict = E_SPACE;
    else if (is_sel) begin
      if (mask_empty)                     verdict = E_EMPTY;
      else if (mask_mixed)                verdict = E_MIX;
    end else begin
      if (len_bad)                        verdict = E_LENGTH;
      else if (off_bad)                   verdict = E_OFFSET;
      else if (is_lut && wrap_bad)        verdict = E_WRAP;
    end
  end

  assign op_fire = op_valid && !buf_clear;
  assign accept  = (verdict == E_NONE);
  assign commit  = op_fire && accept;

  rcs_track #(.IDX_W(IDX_W)) u_track (
    .clk(clk), .rst_n(rst_n), .clear(buf_clear), .commit(commit),
    .kind(op_kind), .need(need),
    .index(fill_index), .next_ok(next_ok), .done(done_mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_ok    <= 1'b0;
      resp_err   <= E_NONE;
    end else begin
      resp_valid <= op_fire;
      resp_ok    <= op_fire && accept;
      resp_err   <= op_fire ? verdict : E_NONE;
    end
  end

  a_r10_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && !accept) |=> ($stable(fill_index) && $stable(next_ok) && $stable(done_mask)));

  a_r11_kick_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && is_kick && accept) |-> ((done_mask == 2'b11) && (fill_index != '0)));

  a_r2_write_after_select: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && is_wr && accept) |-> done_mask[0]);

  a_r4_select_mask_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && is_sel && accept) |-> ((blk_mask != '0) && !((|blk_mask[GRP_A_W-1:0]) && (|blk_mask[MASK_W-1:GRP_A_W]))));

  a_r14_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clear |=> !resp_valid);
endmodule

// File: tb/tb_rcs_validator.sv
module tb_rcs_validator;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W  = 10;
  localparam int LEN_MX = 15;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              buf_clear = 1'b0;
  logic              op_valid = 1'b0;
  logic [2:0]        op_kind = '0;
  logic [7:0]        blk_mask = '0;
  logic [31:0]       wr_offset = '0;
  logic [31:0]       data_len = '0;
  logic [4:0]        wrap_size = '0;
  logic [IDX_W-1:0]  buf_cap = 10'd1000;
  logic              resp_valid, resp_ok;
  logic [3:0]        resp_err;
  logic [IDX_W-1:0]  fill_index;
  logic [1:0]        next_ok, done_mask;

  int n_cmp = 0;
  int n_bad = 0;
  // bench model state
  int m_idx = 0;
  int m_next = 1;
  int m_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rcs_validator #(.IDX_W(IDX_W), .LEN_DW_MAX(LEN_MX)) dut (
    .clk(clk), .rst_n(rst_n), .buf_clear(buf_clear), .op_valid(op_valid),
    .op_kind(op_kind), .blk_mask(blk_mask), .wr_offset(wr_offset),
    .data_len(data_len), .wrap_size(wrap_size), .buf_cap(buf_cap),
    .resp_valid(resp_valid), .resp_ok(resp_ok), .resp_err(resp_err),
    .fill_index(fill_index), .next_ok(next_ok), .done_mask(done_mask));

  function automatic int model_err(int k, int m, longint off, longint len, int w);
    longint room;
    longint cost;
    room = longint'(buf_cap) - m_idx;
    if (room < 0) room = 0;
    cost = (k == 0) ? 8 : 8 + len;
    if (k > 5) return 1;
    if (k == 5) return (m_done == 3 && m_idx > 0) ? 0 : 9;
    if (k == 0 && (m_next % 2) == 0) return 2;
    if (k != 0 && (m_next / 2) == 0) return 2;
    if (cost > room) return 3;
    if (k == 0) begin
      if (m == 0) return 4;
      if ((m % 16) != 0 && (m / 16) != 0) return 5;
      return 0;
    end
    if ((len % 4) != 0 || (len / 4) > LEN_MX) return 6;
    if ((off % 4) != 0 || off > 64'hFFFFF) return 7;
    if (k == 4 && (w < 2 || w > 15)) return 8;
    return 0;
  endfunction

  task automatic check_state(string tag);
    n_cmp++;
    if (fill_index != IDX_W'(m_idx) || next_ok != 2'(m_next) || done_mask != 2'(m_done)) begin
      n_bad++;
      $display("FAIL %s state: got idx=%0d next=%b done=%b exp idx=%0d next=%b done=%b",
               tag, fill_index, next_ok, done_mask, m_idx, 2'(m_next), 2'(m_done));
    end
  endtask

  task automatic do_op(string tag, int k, int m, longint off, longint len, int w);
    int e;
    e = model_err(k, m, off, len, w);
    @(negedge clk);
    op_kind = 3'(k); blk_mask = 8'(m); wr_offset = 32'(off);
    data_len = 32'(len); wrap_size = 5'(w); op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    if (e == 0) begin
      if (k == 0) begin m_idx += 8; m_next = 2; m_done |= 1; end
      else if (k >= 1 && k <= 3) begin m_idx += 8 + int'(len); m_next = 3; m_done |= 2; end
      else if (k == 4) begin m_idx += 8 + int'(len); m_next = 2; m_done |= 2; end
    end
    n_cmp++;
    if (!resp_valid || resp_ok != (e == 0) || resp_err != 4'(e)) begin
      n_bad++;
      $display("FAIL %s kind=%0d: got v=%b ok=%b err=%0d exp v=1 ok=%b err=%0d",
               tag, k, resp_valid, resp_ok, resp_err, e == 0, e);
    end
    check_state(tag);
  endtask

  task automatic do_clear();
    @(negedge clk);
    buf_clear = 1'b1;
    @(negedge clk);
    buf_clear = 1'b0;
    m_idx = 0; m_next = 1; m_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 reset");

    // R2 / R11 / R12 before any select
    for (int k = 1; k <= 4; k++) do_op("R2 write before select", k, 0, 0, 4, 2);
    do_op("R11 kick on empty buffer", 5, 0, 0, 0, 0);
    do_op("R12 undefined kind 6", 6, 1, 0, 0, 0);
    do_op("R12 undefined kind 7", 7, 1, 0, 0, 0);

    // R4 exhaustive mask sweep
    buf_cap = 10'd64;
    for (int m = 0; m < 256; m++) begin
      do_clear();
      do_op("R4 mask sweep", 0, m, 0, 0, 0);
    end

    // R6 / R9 length sweep with incrementing write; wrap 0 ignored (R7)
    buf_cap = 10'd1000;
    for (int l = 0; l <= 70; l++) begin
      do_clear();
      do_op("R9 select", 0, 1, 0, 0, 0);
      do_op("R6 length sweep", 2, 0, 0, l, 0);
    end

    // R5 offsets
    begin
      longint offs[9] = '{0, 4, 3, 2, 64'hFFFFC, 64'hFFFFF, 64'h100000, 64'h100004, 64'hFFFFFFFC};
      foreach (offs[i]) begin
        do_clear();
        do_op("R5 select", 0, 8'h10, 0, 0, 0);
        do_op("R5 offset", 1, 0, offs[i], 4, 0);
      end
    end

    // R7 wrap sweep for lookup-table writes
    for (int w = 0; w < 32; w++) begin
      do_clear();
      do_op("R7 select", 0, 2, 0, 0, 0);
      do_op("R7 wrap sweep", 4, 0, 8, 8, w);
    end

    // R3 ordering walk
    do_clear();
    check_state("R1 clear");
    do_op("R3 select", 0, 8'h20, 0, 0, 0);
    do_op("R3 select twice", 0, 8'h20, 0, 0, 0);
    do_op("R3 lut write", 4, 0, 0, 16, 4);
    do_op("R3 select after lut", 0, 1, 0, 0, 0);
    do_op("R3 inc write", 2, 0, 4, 8, 0);
    do_op("R3 select after inc", 0, 1, 0, 0, 0);
    do_op("R3 single write", 1, 0, 12, 4, 0);
    do_op("R3 indexed write", 3, 0, 16, 12, 0);
    do_op("R11 kick granted", 5, 0, 0, 0, 0);
    do_op("R11 kick again", 5, 0, 0, 0, 0);

    // R8 space
    buf_cap = 10'd24;
    do_clear();
    do_op("R8 select", 0, 1, 0, 0, 0);
    do_op("R8 exact fit", 2, 0, 0, 8, 0);
    do_op("R8 full", 2, 0, 0, 0, 0);
    buf_cap = 10'd20;
    do_clear();
    do_op("R8 select", 0, 1, 0, 0, 0);
    do_op("R8 short by four", 2, 0, 0, 8, 0);
    buf_cap = 10'd4;
    do_clear();
    do_op("R8 select no room", 0, 1, 0, 0, 0);

    // R13 priority
    buf_cap = 10'd1000;
    do_clear();
    do_op("R13 order before all", 4, 0, 3, 5, 0);
    do_op("R13 empty before mix", 0, 0, 0, 0, 0);
    do_op("R13 select", 0, 1, 0, 0, 0);
    do_op("R13 length before offset", 4, 0, 3, 6, 0);
    do_op("R13 offset before wrap", 4, 0, 3, 8, 0);
    buf_cap = 10'd20;
    do_op("R13 space before length", 4, 0, 3, 66, 0);

    // R14 clear with simultaneous op
    buf_cap = 10'd1000;
    do_clear();
    do_op("R14 select", 0, 1, 0, 0, 0);
    @(negedge clk);
    buf_clear = 1'b1; op_valid = 1'b1; op_kind = 3'd2; data_len = 32'd4; wr_offset = 32'd0;
    @(negedge clk);
    buf_clear = 1'b0; op_valid = 1'b0;
    m_idx = 0; m_next = 1; m_done = 0;
    n_cmp++;
    if (resp_valid) begin
      n_bad++;
      $display("FAIL R14 response: got resp_valid=%b exp 0", resp_valid);
    end
    check_state("R14 clear wins");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule